// File: doc/BRIEF.md
# Streaming video line packetizer

This block turns a raster of pixels, offered one pixel per handshake, into a lite-variant AXI4-Stream video stream. It gathers `PIP` consecutive pixels of a line into one beat and places each pixel in a byte-aligned, zero-padded slot. Each video line becomes one packet. The stream carries a frame-start mark, an end-of-line mark and an interlaced field flag on TUSER and TLAST. The image size is fixed by parameters: `WIDTH` pixels per line and `HEIGHT` lines per frame or field. The block counts positions itself, so the source only supplies pixels in raster order and the field flag of each frame.

A single output register holds each finished beat until the sink takes it. Pixels that only fill a slot are always accepted. A pixel that would complete a beat is accepted only when the output register is empty, or is being emptied in that same cycle. Progressive video is sent by holding the field flag low.

Top module: `vid_line_packetizer`

## Requirements
- R1: A pixel slot is SLOT_W = 8*max(2, ceil(BPS*SYM/8)) bits wide and `out_data` is SLOT_W*PIP bits wide. The pixel with the lowest horizontal position of a beat sits in bits [SLOT_W-1:0] and the next pixel in the slot above it. Within a slot the pixel word `in_pix` (colour symbol k at bits [k*BPS +: BPS]) starts at bit 0, and every bit above BPS*SYM is zero.
- R2: `out_user` is `out_data` width / 8 bits wide, and every bit above bit 1 is zero on every valid beat.
- R3: Each line goes out as WIDTH/PIP beats. `out_last` is high on the beat that carries the line's last pixel and low on every other beat.
- R4: `out_user[0]` is high on the first beat of a frame or field and low on every other beat.
- R5: `out_user[1]` equals the value of `in_f1` on the first pixel of the frame and holds that value on every beat of the frame. `in_f1` on later pixels has no effect.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_user` and `out_last` keep their values into the next cycle.
- R7: After HEIGHT lines, the line position wraps, and the next beat is the first beat of a new frame.
- R8: After reset, `out_valid` is low and `in_ready` is high.
- R9: `in_ready` is high for a pixel that does not complete a beat. It is low for a pixel that completes a beat while a held beat is not being taken. No pixel is lost or sent twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A pixel is offered |
| in_ready | output | 1 | The offered pixel is accepted this cycle |
| in_pix | input | BPS*SYM | Pixel, symbol k at bits [k*BPS +: BPS] |
| in_f1 | input | 1 | Field flag, taken from the first pixel of a frame |
| out_valid | output | 1 | A beat is presented |
| out_ready | input | 1 | The sink takes the beat |
| out_data | output | 8*max(2,ceil(BPS*SYM/8))*PIP | Packed pixel slots |
| out_user | output | out_data width / 8 | Bit 0: frame start, bit 1: F1 field, rest zero |
| out_last | output | 1 | Last beat of a line |

## Verification
Two events can fall in the same clock edge: the sink takes the held beat, and a pixel completes the next beat and loads the output register. The bench provokes this in two ways. It holds `out_ready` low for several cycles until a beat-completing pixel is stalled, then raises it. It also toggles `out_ready` every cycle while pixels arrive with gaps. The edge is judged by the beat contents and order that follow: each beat must carry the expected pixels, frame-start, field and line-end marks. The frame must hold exactly HEIGHT*WIDTH/PIP beats, so a beat dropped or repeated on that edge is caught. `in_ready` is checked against the stall state before every accepted pixel.

// File: rtl/vpk_pkg.sv
package vpk_pkg;

  // bytes taken by one pixel slot on the stream
  function automatic int slot_bytes(input int bps, input int sym);
    int b;
    b = (bps * sym + 7) / 8;
    return (b < 2) ? 2 : b;
  endfunction

  function automatic int slot_bits(input int bps, input int sym);
    return 8 * slot_bytes(bps, sym);
  endfunction

  function automatic int data_bits(input int bps, input int sym, input int pip);
    return slot_bits(bps, sym) * pip;
  endfunction

  function automatic int user_bits(input int bps, input int sym, input int pip);
    int u;
    u = data_bits(bps, sym, pip) / 8;
    return (u < 2) ? 2 : u;
  endfunction

  // index width for a counter running 0..n-1
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/vpk_raster_pos.sv
module vpk_raster_pos #(
  parameter int PIP    = 2,
  parameter int WIDTH  = 8,
  parameter int HEIGHT = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             adv,
  output logic [vpk_pkg::idx_w(PIP)-1:0]   lane_o,
  output logic                             lane_last_o,
  output logic                             first_pix_o,
  output logic                             frame_beat_o,
  output logic                             line_end_o
);
  localparam int BEATS = WIDTH / PIP;
  localparam int LW    = vpk_pkg::idx_w(PIP);
  localparam int BW    = vpk_pkg::idx_w(BEATS);
  localparam int YW    = vpk_pkg::idx_w(HEIGHT);

  logic [LW-1:0] lane_q;
  logic [BW-1:0] bx_q;
  logic [YW-1:0] y_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q <= '0;
      bx_q   <= '0;
      y_q    <= '0;
    end else if (adv) begin
      if (lane_last_o) begin
        lane_q <= '0;
        if (line_end_o) begin
          bx_q <= '0;
          y_q  <= (y_q == YW'(HEIGHT - 1)) ? '0 : y_q + 1'b1;
        end else begin
          bx_q <= bx_q + 1'b1;
        end
      end else begin
        lane_q <= lane_q + 1'b1;
      end
    end
  end

  assign lane_o       = lane_q;
  assign lane_last_o  = (lane_q == LW'(PIP - 1));
  assign line_end_o   = (bx_q == BW'(BEATS - 1));
  assign frame_beat_o = (bx_q == '0) && (y_q == '0);
  assign first_pix_o  = frame_beat_o && (lane_q == '0);

  // positions stay inside the raster
  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (bx_q <= BW'(BEATS - 1)) && (y_q <= YW'(HEIGHT - 1))) else $error("raster position out of range"); // R7
endmodule

// File: rtl/vpk_lane_pack.sv
module vpk_lane_pack #(
  parameter int PIX_BITS = 30,
  parameter int SLOT_W   = 32,
  parameter int PIP      = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             adv,
  input  logic [vpk_pkg::idx_w(PIP)-1:0]   lane,
  input  logic [PIX_BITS-1:0]              pix,
  output logic [SLOT_W*PIP-1:0]            beat_o
);
  localparam int LW = vpk_pkg::idx_w(PIP);

  for (genvar g = 0; g < PIP; g++) begin : g_lane
    if (g < PIP - 1) begin : g_store
      logic [PIX_BITS-1:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       slot_q <= '0;
        else if (adv && lane == LW'(g))   slot_q <= pix;
      end
      assign beat_o[g*SLOT_W +: SLOT_W] = SLOT_W'(slot_q);
    end else begin : g_live
      // the pixel that completes the beat goes straight to the top slot
      assign beat_o[g*SLOT_W +: SLOT_W] = SLOT_W'(pix);
    end
  end
endmodule

// File: rtl/vpk_beat_reg.sv
module vpk_beat_reg #(
  parameter int DATA_W = 64,
  parameter int USER_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] d_data,
  input  logic              d_sof,
  input  logic              d_eol,
  input  logic              d_f1,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [USER_W-1:0] out_user,
  output logic              out_last,
  output logic              free_o
);
  logic sof_q, f1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
      sof_q     <= 1'b0;
      f1_q      <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= d_data;
      out_last  <= d_eol;
      sof_q     <= d_sof;
      f1_q      <= d_f1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_comb begin
    out_user    = '0;
    out_user[0] = sof_q;
    out_user[1] = f1_q;
  end

  assign free_o = !out_valid || out_ready;

  AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_user) && $stable(out_last)) else $error("beat changed under stall"); // R6
  AST_LOAD_INTO_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> free_o) else $error("beat overwritten"); // R9
endmodule

// File: rtl/vid_line_packetizer.sv
module vid_line_packetizer #(
  parameter int BPS    = 10,
  parameter int SYM    = 3,
  parameter int PIP    = 2,
  parameter int WIDTH  = 8,
  parameter int HEIGHT = 4
) (
  input  logic                                              clk,
  input  logic                                              rst_n,
  input  logic                                              in_valid,
  output logic                                              in_ready,
  input  logic [BPS*SYM-1:0]                                in_pix,
  input  logic                                              in_f1,
  output logic                                              out_valid,
  input  logic                                              out_ready,
  output logic [vpk_pkg::data_bits(BPS, SYM, PIP)-1:0]      out_data,
  output logic [vpk_pkg::user_bits(BPS, SYM, PIP)-1:0]      out_user,
  output logic                                              out_last
);
  localparam int PIX_BITS = BPS * SYM;
  localparam int SLOT_W   = vpk_pkg::slot_bits(BPS, SYM);
  localparam int DATA_W   = vpk_pkg::data_bits(BPS, SYM, PIP);
  localparam int USER_W   = vpk_pkg::user_bits(BPS, SYM, PIP);
  localparam int BEATS    = WIDTH / PIP;
  localparam int LW       = vpk_pkg::idx_w(PIP);
  localparam int BW       = vpk_pkg::idx_w(BEATS);
  localparam int YW       = vpk_pkg::idx_w(HEIGHT);

  if ((WIDTH % PIP) != 0 || PIP < 1 || HEIGHT < 1) begin : g_bad_cfg
    $error("WIDTH must be a whole multiple of PIP");
  end

  // named internal events
  logic [LW-1:0]     lane;
  logic              lane_last, first_pix, frame_beat, line_end;
  logic              pix_take, beat_load, beat_free, f1_now, f1_q;
  logic [DATA_W-1:0] beat_data;

  assign in_ready  = !lane_last || beat_free;
  assign pix_take  = in_valid && in_ready;
  assign beat_load = pix_take && lane_last;
  assign f1_now    = first_pix ? in_f1 : f1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    f1_q <= 1'b0;
    else if (pix_take && first_pix) f1_q <= in_f1;
  end

  vpk_raster_pos #(.PIP(PIP), .WIDTH(WIDTH), .HEIGHT(HEIGHT)) i_pos (
    .clk(clk), .rst_n(rst_n), .adv(pix_take),
    .lane_o(lane), .lane_last_o(lane_last), .first_pix_o(first_pix),
    .frame_beat_o(frame_beat), .line_end_o(line_end)
  );

  vpk_lane_pack #(.PIX_BITS(PIX_BITS), .SLOT_W(SLOT_W), .PIP(PIP)) i_pack (
    .clk(clk), .rst_n(rst_n), .adv(pix_take), .lane(lane),
    .pix(in_pix), .beat_o(beat_data)
  );

  vpk_beat_reg #(.DATA_W(DATA_W), .USER_W(USER_W)) i_beat (
    .clk(clk), .rst_n(rst_n), .load(beat_load), .d_data(beat_data),
    .d_sof(frame_beat), .d_eol(line_end), .d_f1(f1_now),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .out_user(out_user), .out_last(out_last), .free_o(beat_free)
  );

  // independent position tracking on the output side, for the checks below
  logic          out_take;
  logic [BW-1:0] chk_col;
  logic [YW-1:0] chk_row;
  logic          chk_seen, chk_f1;

  assign out_take = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_col  <= '0;
      chk_row  <= '0;
      chk_seen <= 1'b0;
      chk_f1   <= 1'b0;
    end else if (out_take) begin
      chk_seen <= 1'b1;
      chk_f1   <= out_user[1];
      if (chk_col == BW'(BEATS - 1)) begin
        chk_col <= '0;
        chk_row <= (chk_row == YW'(HEIGHT - 1)) ? '0 : chk_row + 1'b1;
      end else begin
        chk_col <= chk_col + 1'b1;
      end
    end
  end

  AST_SOF_POS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_user[0] == (chk_col == '0 && chk_row == '0)) else $error("frame start misplaced"); // R4, R7
  AST_LAST_POS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_last == (chk_col == BW'(BEATS - 1))) else $error("line end misplaced"); // R3
  AST_F1_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_user[0] && chk_seen |-> out_user[1] == chk_f1) else $error("field flag changed in frame"); // R5
  if (USER_W > 2) begin : g_user_hi
    AST_USER_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_user[USER_W-1:2] == '0) else $error("upper user bits set"); // R2
  end
endmodule

// File: tb/test_vid_line_packetizer.sv
`timescale 1ns/1ps
module test_vid_line_packetizer;
  localparam int BPS = 10, SYM = 3, PIP = 2, WIDTH = 8, HEIGHT = 4;
  localparam int PB   = BPS * SYM;
  localparam int SB   = ((PB + 7) / 8 < 2) ? 2 : (PB + 7) / 8;
  localparam int SW   = SB * 8;
  localparam int DW   = SW * PIP;
  localparam int UW   = DW / 8;
  localparam int BPL  = WIDTH / PIP;
  localparam int FB   = BPL * HEIGHT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [PB-1:0] in_pix = '0;
  logic in_f1 = 1'b0;
  logic in_ready, out_valid, out_last;
  logic out_ready = 1'b0;
  logic [DW-1:0] out_data;
  logic [UW-1:0] out_user;

  int n_checks = 0, n_fail = 0;
  int ready_mode = 0;
  int beats_seen = 0, frames_sent = 0;
  int mon_fr = 0, mon_y = 0, mon_bx = 0;
  bit f1_tab [0:63];
  logic [15:0] lfsr = 16'hACE1;
  logic prev_stall = 1'b0;
  logic [DW-1:0] prev_data;
  logic [UW-1:0] prev_user;
  logic prev_last;
  int cyc = 0;

  always #2 clk = ~clk;

  vid_line_packetizer #(.BPS(BPS), .SYM(SYM), .PIP(PIP), .WIDTH(WIDTH), .HEIGHT(HEIGHT)) i_vid_line_packetizer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .in_f1(in_f1), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_user(out_user), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [PB-1:0] pix_val(input int fr, input int y, input int x);
    return PB'((fr * 7919 + y * 131 + x * 17 + 5) ^ 32'h15A5_C3A5);
  endfunction

  function automatic logic [DW-1:0] exp_beat(input int fr, input int y, input int bx);
    logic [DW-1:0] e;
    e = '0;
    for (int l = 0; l < PIP; l++) e[l*SW +: SW] = {{(SW-PB){1'b0}}, pix_val(fr, y, bx * PIP + l)};
    return e;
  endfunction

  // sink side: choose ready, check each taken beat and each stalled beat
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (ready_mode)
        0: out_ready = 1'b1;
        1: out_ready = ~out_ready;
        2: out_ready = lfsr[0];
        default: out_ready = ((cyc % 16) >= 11);
      endcase
      if (prev_stall) begin
        chk(out_valid && out_data == prev_data && out_user == prev_user && out_last == prev_last,
            "R6", "beat held under stall", out_data, prev_data);
      end
      if (out_valid && out_ready) begin
        chk(out_data == exp_beat(mon_fr, mon_y, mon_bx), "R1", "packed pixels",
            out_data, exp_beat(mon_fr, mon_y, mon_bx));
        chk(out_user[0] == (mon_bx == 0 && mon_y == 0), "R4", "frame start bit",
            DW'(out_user[0]), DW'(mon_bx == 0 && mon_y == 0));
        if (mon_fr > 0 && mon_bx == 0 && mon_y == 0)
          chk(out_user[0] == 1'b1, "R7", "wrap to new frame", DW'(out_user[0]), DW'(1));
        chk(out_user[1] == f1_tab[mon_fr], "R5", "field flag", DW'(out_user[1]), DW'(f1_tab[mon_fr]));
        chk((out_user >> 2) == '0, "R2", "upper user bits", DW'(out_user), DW'(out_user[1:0]));
        chk(out_last == (mon_bx == BPL - 1), "R3", "line end", DW'(out_last), DW'(mon_bx == BPL - 1));
        beats_seen++;
        if (mon_bx == BPL - 1) begin
          mon_bx = 0;
          if (mon_y == HEIGHT - 1) begin mon_y = 0; mon_fr++; end
          else mon_y++;
        end else mon_bx++;
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      prev_user  = out_user;
      prev_last  = out_last;
    end
  end

  task automatic push(input logic [PB-1:0] v, input logic f, input int lane);
    bit acc;
    in_valid = 1'b1;
    in_pix   = v;
    in_f1    = f;
    do begin
      #1;
      if (lane != PIP - 1)
        chk(in_ready, "R9", "slot-filling pixel accepted", DW'(in_ready), DW'(1));
      else if (out_valid && !out_ready)
        chk(!in_ready, "R9", "completing pixel stalled", DW'(in_ready), DW'(0));
      acc = in_ready;
      @(negedge clk);
    end while (!acc);
    in_valid = 1'b0;
  endtask

  // one frame or field: field flag, input gaps, sink ready pattern
  task automatic run_frame(input bit f1, input int gap, input int rmode);
    int fr, target, t;
    ready_mode = rmode;
    fr = frames_sent;
    f1_tab[fr] = f1;
    for (int y = 0; y < HEIGHT; y++)
      for (int x = 0; x < WIDTH; x++) begin
        // later pixels carry the opposite flag, which must be ignored (R5)
        push(pix_val(fr, y, x), (y == 0 && x == 0) ? f1 : ~f1, x % PIP);
        if (gap != 0 && ((x + y) % gap) == 0) @(negedge clk);
      end
    frames_sent++;
    target = frames_sent * FB;
    t = 0;
    while (beats_seen < target && t < 2000) begin @(negedge clk); t++; end
    chk(beats_seen == target, "R3", "beats per frame", DW'(beats_seen), DW'(target));
    repeat (3) @(negedge clk);
    chk(beats_seen == target, "R9", "no extra beats", DW'(beats_seen), DW'(target));
  endtask

  task automatic reset_check();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!out_valid, "R8", "valid after reset", DW'(out_valid), DW'(0));
    chk(in_ready, "R8", "ready after reset", DW'(in_ready), DW'(1));
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    reset_check();
    run_frame(1'b0, 0, 0);   // progressive, free-flowing
    run_frame(1'b1, 3, 1);   // F1 field, gaps, toggling ready
    run_frame(1'b0, 2, 2);   // F0 field, pseudo-random ready
    run_frame(1'b1, 0, 3);   // F1 field, long stalls: drain and load on one edge
    run_frame(1'b1, 5, 2);   // back-to-back F1 after F1
    finish_run();
  end
endmodule